// File: doc/BRIEF.md
# Packet-Driven Multichannel DMA Engine

This engine moves data across a simple memory-mapped bus without processor involvement. Every block transfer is described by a four-word control packet kept in an internal descriptor store. A packet holds a configuration word, a source address, a destination address and an element count. A channel is bound to one packet. When the channel is enabled and its packet is armed, the engine moves the block one element at a time. Each element is a single-beat read followed by a single-beat write on the master port.

Each channel runs in one of two modes. In free-running mode it moves its whole block back to back, which suits memory-to-memory copies. In request-paced mode it moves one element for every rising edge on that channel's request line, which suits peripheral traffic. When several channels are ready at once, the lowest-numbered one wins. Arbitration is repeated after every element. When a block finishes, the engine disarms the packet and latches a per-packet done flag. If the packet's interrupt-enable bit is set, that flag raises the interrupt output. Software clears the flag through a write-one-to-clear location. It restarts the block by writing a new count and re-arming the packet, and the block then continues from the addresses where it stopped.

Top module: `pkt_dma`

## Requirements
- R1: After reset the bus request and the interrupt output are low, and every channel and packet is disarmed with its done flag clear.
- R2: Packet n occupies configuration bytes 16n to 16n+15: offset 0 is the configuration word, 4 the source address, 8 the destination address, 12 the count. Configuration bit 0 increments the source, bit 1 increments the destination, bits 3:2 give the size (00 byte, 01 half-word, 10 word), and bit 4 is the interrupt enable.
- R3: The word at 0x400+4c binds channel c. Bits 4:0 select the packet, bit 8 enables the channel, and bit 9 selects request-paced mode. Writing 1s to 0x800 arms packets, to 0x808 disarms them, and to 0x804 clears their done flags.
- R4: In free-running mode an armed packet on an enabled channel moves exactly count elements. Each element is one read followed by one write of the same data.
- R5: After each element, an address whose increment bit is set advances by the element size (1, 2 or 4 bytes). An address whose bit is clear stays fixed.
- R6: A byte element uses the lane given by address bits 1:0. A half-word element uses lanes 1:0 or 3:2, chosen by address bit 1. A word uses all four lanes. The write byte enables mark exactly the lanes written.
- R7: When the count reaches zero, the packet is disarmed and its done flag is set. The interrupt is high while any done packet has its interrupt enable set. Clearing the flag drops the interrupt.
- R8: In request-paced mode, each rising edge of the channel's request moves exactly one element. A request held high moves only one element, and no element moves without a request edge.
- R9: Among ready channels the lowest-numbered channel is granted. Arbitration is repeated after every element, so a lower channel that becomes ready takes the next element.
- R10: Nothing moves unless the channel is enabled, its packet is armed and the packet's count is non-zero.
- R11: Writing a new count and re-arming a completed packet restarts it from the source and destination addresses reached at completion.
- R12: A bus access stays requested, with its address and direction stable, until a cycle in which the grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| chan_req | input | NUM_CH | Per-channel peripheral request lines |
| bus_req | output | 1 | Master access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address of the access |
| bus_wdata | output | 32 | Write data, element replicated on all lanes |
| bus_be | output | 4 | Byte enables |
| bus_rdata | input | 32 | Read data, valid in a granted read cycle |
| bus_gnt | input | 1 | Access completes in a cycle with grant high |
| irq | output | 1 | Block-completion interrupt |

## Verification
A corrupt stored address or a wrong size decode shows at the ports within one element, about four cycles. It appears as a wrong bus address or byte-enable pattern, and it then leaves wrong bytes in the target memory. A count that is off by one shows when the block ends, as one write too many or too few and an interrupt that comes early or late. A stale request-pending flag or a wrong priority changes the order or the number of write beats, and this is visible on the next arbitration.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

   // configuration word bit positions (R2)
   localparam int CFG_SRC_INC = 0;
   localparam int CFG_DST_INC = 1;
   localparam int CFG_SIZE_LO = 2;
   localparam int CFG_IRQ_EN  = 4;
   localparam int CFG_BITS    = 5;

   // channel binding word bit positions (R3)
   localparam int CHB_EN_BIT  = 8;
   localparam int CHB_REQ_BIT = 9;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } elem_size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_UPDATE
   } xfer_state_e;

   function automatic logic [2:0] size_step(input logic [1:0] sz);
      case (elem_size_e'(sz))
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // right-align the element found at byte offset off of a bus word
   function automatic logic [31:0] pick_lane(input logic [31:0] w, input logic [1:0] off,
                                             input logic [1:0] sz);
      logic [31:0] sh;
      case (elem_size_e'(sz))
         SZ_BYTE: begin sh = w >> {off, 3'b000};   return {24'd0, sh[7:0]};  end
         SZ_HALF: begin sh = w >> {off[1], 4'h0};  return {16'd0, sh[15:0]}; end
         default: return w;
      endcase
   endfunction

   // replicate the element on every lane it could occupy
   function automatic logic [31:0] spread(input logic [31:0] e, input logic [1:0] sz);
      case (elem_size_e'(sz))
         SZ_BYTE: return {4{e[7:0]}};
         SZ_HALF: return {2{e[15:0]}};
         default: return e;
      endcase
   endfunction

   function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
      case (elem_size_e'(sz))
         SZ_BYTE: return 4'b0001 << off;
         SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/pkt_dma_desc.sv
module pkt_dma_desc
   import pkt_dma_pkg::*;
#(
   parameter int NUM_CH   = 16,
   parameter int NUM_PKT  = 32,
   parameter int AW       = 32,
   parameter int CNT_W    = 16,
   parameter int CFG_AW   = 12,
   parameter int CH_BASE  = 'h400,
   parameter int PEN_SET  = 'h800,
   parameter int DONE_CLR = 'h804,
   parameter int PEN_CLR  = 'h808,
   localparam int PKT_IW  = $clog2(NUM_PKT),
   localparam int CH_IW   = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [CFG_AW-1:0]        cfg_addr,
   input  logic [31:0]              cfg_wdata,
   input  logic                     upd_v,
   input  logic [PKT_IW-1:0]        upd_pkt,
   input  logic [AW-1:0]            upd_src,
   input  logic [AW-1:0]            upd_dst,
   input  logic [CNT_W-1:0]         upd_cnt,
   input  logic [PKT_IW-1:0]        rd_pkt,
   output logic [AW-1:0]            rd_src,
   output logic [AW-1:0]            rd_dst,
   output logic [CNT_W-1:0]         rd_cnt,
   output logic [1:0]               rd_size,
   output logic                     rd_sinc,
   output logic                     rd_dinc,
   output logic [NUM_CH*PKT_IW-1:0] ch_pkt_flat,
   output logic [NUM_CH-1:0]        ch_base_rdy,
   output logic [NUM_CH-1:0]        ch_rq,
   output logic                     irq
);

   localparam int DESC_BYTES = NUM_PKT * 16;
   localparam int CH_BYTES   = NUM_CH * 4;

   logic [CFG_BITS-1:0] cfgw_q [NUM_PKT];
   logic [AW-1:0]       src_q  [NUM_PKT];
   logic [AW-1:0]       dst_q  [NUM_PKT];
   logic [CNT_W-1:0]    cnt_q  [NUM_PKT];
   logic [PKT_IW-1:0]   bind_q [NUM_CH];
   logic [NUM_CH-1:0]   chen_q, rq_q;
   logic [NUM_PKT-1:0]  pen_q, pen_nxt, done_q, done_nxt;

   logic                desc_hit, ch_hit;
   logic [PKT_IW-1:0]   w_pkt;
   logic [1:0]          w_word;
   logic [CFG_AW-1:0]   ch_off;
   logic [CH_IW-1:0]    w_ch;

   assign desc_hit = cfg_addr < CFG_AW'(DESC_BYTES);
   assign w_pkt    = cfg_addr[PKT_IW+3:4];
   assign w_word   = cfg_addr[3:2];
   assign ch_off   = cfg_addr - CFG_AW'(CH_BASE);
   assign ch_hit   = (cfg_addr >= CFG_AW'(CH_BASE)) && (ch_off < CFG_AW'(CH_BYTES));
   assign w_ch     = ch_off[CH_IW+1:2];

   // arm / done bookkeeping: engine completion first, software strobes after (R3, R7)
   always_comb begin
      pen_nxt  = pen_q;
      done_nxt = done_q;
      if (upd_v && upd_cnt == '0) begin
         pen_nxt[upd_pkt]  = 1'b0;
         done_nxt[upd_pkt] = 1'b1;
      end
      if (cfg_we && cfg_addr == CFG_AW'(PEN_SET))  pen_nxt  = pen_nxt | cfg_wdata[NUM_PKT-1:0];
      if (cfg_we && cfg_addr == CFG_AW'(PEN_CLR))  pen_nxt  = pen_nxt & ~cfg_wdata[NUM_PKT-1:0];
      if (cfg_we && cfg_addr == CFG_AW'(DONE_CLR)) done_nxt = done_nxt & ~cfg_wdata[NUM_PKT-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PKT; p++) begin
            cfgw_q[p] <= '0;
            src_q[p]  <= '0;
            dst_q[p]  <= '0;
            cnt_q[p]  <= '0;
         end
         for (int c = 0; c < NUM_CH; c++) bind_q[c] <= '0;
         chen_q <= '0;
         rq_q   <= '0;
         pen_q  <= '0;
         done_q <= '0;
      end else begin
         pen_q  <= pen_nxt;
         done_q <= done_nxt;
         if (upd_v) begin
            src_q[upd_pkt] <= upd_src;
            dst_q[upd_pkt] <= upd_dst;
            cnt_q[upd_pkt] <= upd_cnt;
         end
         if (cfg_we && desc_hit) begin
            case (w_word)
               2'd0:    cfgw_q[w_pkt] <= cfg_wdata[CFG_BITS-1:0];
               2'd1:    src_q[w_pkt]  <= cfg_wdata[AW-1:0];
               2'd2:    dst_q[w_pkt]  <= cfg_wdata[AW-1:0];
               default: cnt_q[w_pkt]  <= cfg_wdata[CNT_W-1:0];
            endcase
         end
         if (cfg_we && ch_hit) begin
            bind_q[w_ch] <= cfg_wdata[PKT_IW-1:0];
            chen_q[w_ch] <= cfg_wdata[CHB_EN_BIT];
            rq_q[w_ch]   <= cfg_wdata[CHB_REQ_BIT];
         end
      end
   end

   assign rd_src  = src_q[rd_pkt];
   assign rd_dst  = dst_q[rd_pkt];
   assign rd_cnt  = cnt_q[rd_pkt];
   assign rd_size = cfgw_q[rd_pkt][CFG_SIZE_LO +: 2];
   assign rd_sinc = cfgw_q[rd_pkt][CFG_SRC_INC];
   assign rd_dinc = cfgw_q[rd_pkt][CFG_DST_INC];

   // per-channel readiness, before request pacing (R10)
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_pkt_flat[c*PKT_IW +: PKT_IW] = bind_q[c];
      assign ch_base_rdy[c] = chen_q[c] & pen_q[bind_q[c]] & (cnt_q[bind_q[c]] != '0);
      assign ch_rq[c]       = rq_q[c];
   end

   always_comb begin
      irq = 1'b0;
      for (int p = 0; p < NUM_PKT; p++) irq = irq | (done_q[p] & cfgw_q[p][CFG_IRQ_EN]);
   end

   // R7: a block reaching zero disarms its packet and flags it done
   p_done_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_v && upd_cnt == '0 && !cfg_we) |=> (done_q[$past(upd_pkt)] && !pen_q[$past(upd_pkt)]));

   // R7: interrupt only with some packet done
   p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done_q != '0));

endmodule

// File: rtl/pkt_dma_req.sv
module pkt_dma_req #(
   parameter int NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] pend_o
);

   logic [NUM_CH-1:0] req_q, pend_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
      logic rise;
      assign rise = req_i[c] & ~req_q[c];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[c]  <= 1'b0;
            pend_q[c] <= 1'b0;
         end else begin
            req_q[c]  <= req_i[c];
            pend_q[c] <= (pend_q[c] & ~clr_i[c]) | rise;
         end
      end

      // R8: a held request does not re-arm after its element completes
      p_one_per_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[c] && req_q[c]) |=> !pend_q[c]);
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/pkt_dma_arb.sv
module pkt_dma_arb #(
   parameter int NUM_CH = 16,
   localparam int CH_IW = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] base_rdy,
   input  logic [NUM_CH-1:0] rq_mode,
   input  logic [NUM_CH-1:0] pend,
   output logic              grant_v,
   output logic [CH_IW-1:0]  grant_idx
);

   logic [NUM_CH-1:0] ready;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_rdy
      assign ready[c] = base_rdy[c] & (~rq_mode[c] | pend[c]);
   end

   // fixed priority, lowest index first (R9)
   always_comb begin
      grant_v   = 1'b0;
      grant_idx = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (ready[c]) begin
            grant_v   = 1'b1;
            grant_idx = CH_IW'(c);
         end
      end
   end

   // R9: nobody below the granted channel is ready
   p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_v |-> (base_rdy[grant_idx] && ((ready & ((NUM_CH'(1) << grant_idx) - NUM_CH'(1))) == '0)));

   // R8: a paced channel is granted only with a pending request
   p_paced_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_v && rq_mode[grant_idx]) |-> pend[grant_idx]);

endmodule

// File: rtl/pkt_dma_xfer.sv
module pkt_dma_xfer
   import pkt_dma_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int NUM_PKT = 32,
   parameter int AW      = 32,
   parameter int CNT_W   = 16,
   localparam int PKT_IW = $clog2(NUM_PKT),
   localparam int CH_IW  = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     grant_v,
   input  logic [CH_IW-1:0]         grant_idx,
   input  logic [NUM_CH*PKT_IW-1:0] ch_pkt_flat,
   output logic [PKT_IW-1:0]        rd_pkt,
   input  logic [AW-1:0]            rd_src,
   input  logic [AW-1:0]            rd_dst,
   input  logic [CNT_W-1:0]         rd_cnt,
   input  logic [1:0]               rd_size,
   input  logic                     rd_sinc,
   input  logic                     rd_dinc,
   output logic                     upd_v,
   output logic [PKT_IW-1:0]        upd_pkt,
   output logic [AW-1:0]            upd_src,
   output logic [AW-1:0]            upd_dst,
   output logic [CNT_W-1:0]         upd_cnt,
   output logic [NUM_CH-1:0]        clr_o,
   output logic                     bus_req,
   output logic                     bus_we,
   output logic [AW-1:0]            bus_addr,
   output logic [31:0]              bus_wdata,
   output logic [3:0]               bus_be,
   input  logic [31:0]              bus_rdata,
   input  logic                     bus_gnt
);

   xfer_state_e       st_q;
   logic [CH_IW-1:0]  ch_q;
   logic [PKT_IW-1:0] pkt_q;
   logic [31:0]       elem_q;
   logic [AW-1:0]     step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ch_q   <= '0;
         pkt_q  <= '0;
         elem_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (grant_v) begin
               ch_q  <= grant_idx;
               pkt_q <= ch_pkt_flat[int'(grant_idx)*PKT_IW +: PKT_IW];
               st_q  <= ST_READ;
            end
            ST_READ: if (bus_gnt) begin
               elem_q <= pick_lane(bus_rdata, rd_src[1:0], rd_size);
               st_q   <= ST_WRITE;
            end
            ST_WRITE: if (bus_gnt) st_q <= ST_UPDATE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_pkt    = pkt_q;
   assign bus_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign bus_we    = (st_q == ST_WRITE);
   assign bus_addr  = bus_we ? rd_dst : rd_src;
   assign bus_wdata = spread(elem_q, rd_size);
   assign bus_be    = bus_we ? lane_mask(rd_dst[1:0], rd_size) : 4'b1111;

   assign step    = AW'(size_step(rd_size));
   assign upd_v   = (st_q == ST_UPDATE);
   assign upd_pkt = pkt_q;
   assign upd_src = rd_sinc ? rd_src + step : rd_src;
   assign upd_dst = rd_dinc ? rd_dst + step : rd_dst;
   assign upd_cnt = rd_cnt - CNT_W'(1);
   assign clr_o   = upd_v ? (NUM_CH'(1) << ch_q) : '0;

   // R12: an ungranted access is held unchanged
   p_hold_until_gnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R6: a write enables one, two or four lanes
   p_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                               $countones(bus_be) == 4));

   // R4: every write is preceded by a granted read
   p_read_before_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !$past(bus_we)) |-> ($past(bus_req) && $past(bus_gnt)));

endmodule

// File: rtl/pkt_dma.sv
module pkt_dma #(
   parameter int NUM_CH   = 16,
   parameter int NUM_PKT  = 32,
   parameter int AW       = 32,
   parameter int CNT_W    = 16,
   parameter int CFG_AW   = 12,
   parameter int CH_BASE  = 'h400,
   parameter int PEN_SET  = 'h800,
   parameter int DONE_CLR = 'h804,
   parameter int PEN_CLR  = 'h808
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic [NUM_CH-1:0] chan_req,
   output logic              bus_req,
   output logic              bus_we,
   output logic [AW-1:0]     bus_addr,
   output logic [31:0]       bus_wdata,
   output logic [3:0]        bus_be,
   input  logic [31:0]       bus_rdata,
   input  logic              bus_gnt,
   output logic              irq
);

   localparam int PKT_IW = $clog2(NUM_PKT);
   localparam int CH_IW  = $clog2(NUM_CH);

   // elaboration-time parameter checks
   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_ch
      $error("pkt_dma: NUM_CH must be 2..32");
   end
   if (NUM_PKT < 2 || NUM_PKT > 32 || (1 << PKT_IW) != NUM_PKT) begin : g_bad_pkt
      $error("pkt_dma: NUM_PKT must be a power of two in 2..32");
   end
   if (NUM_PKT * 16 > CH_BASE || CH_BASE + 4 * NUM_CH > PEN_SET) begin : g_bad_map
      $error("pkt_dma: register regions overlap");
   end
   if (PEN_CLR >= (1 << CFG_AW) || CNT_W > 32 || AW > 32 || AW < 3) begin : g_bad_w
      $error("pkt_dma: width parameters out of range");
   end

   logic                     upd_v;
   logic [PKT_IW-1:0]        upd_pkt, rd_pkt;
   logic [AW-1:0]            upd_src, upd_dst, rd_src, rd_dst;
   logic [CNT_W-1:0]         upd_cnt, rd_cnt;
   logic [1:0]               rd_size;
   logic                     rd_sinc, rd_dinc;
   logic [NUM_CH*PKT_IW-1:0] ch_pkt_flat;
   logic [NUM_CH-1:0]        ch_base_rdy, ch_rq, pend, clr;
   logic                     grant_v;
   logic [CH_IW-1:0]         grant_idx;

   pkt_dma_desc #(
      .NUM_CH(NUM_CH), .NUM_PKT(NUM_PKT), .AW(AW), .CNT_W(CNT_W), .CFG_AW(CFG_AW),
      .CH_BASE(CH_BASE), .PEN_SET(PEN_SET), .DONE_CLR(DONE_CLR), .PEN_CLR(PEN_CLR)
   ) desc_i (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
      .upd_v, .upd_pkt, .upd_src, .upd_dst, .upd_cnt,
      .rd_pkt, .rd_src, .rd_dst, .rd_cnt, .rd_size, .rd_sinc, .rd_dinc,
      .ch_pkt_flat, .ch_base_rdy, .ch_rq, .irq
   );

   pkt_dma_req #(.NUM_CH(NUM_CH)) req_i (
      .clk, .rst_n, .req_i(chan_req), .clr_i(clr), .pend_o(pend)
   );

   pkt_dma_arb #(.NUM_CH(NUM_CH)) arb_i (
      .clk, .rst_n, .base_rdy(ch_base_rdy), .rq_mode(ch_rq), .pend,
      .grant_v, .grant_idx
   );

   pkt_dma_xfer #(
      .NUM_CH(NUM_CH), .NUM_PKT(NUM_PKT), .AW(AW), .CNT_W(CNT_W)
   ) xfer_i (
      .clk, .rst_n, .grant_v, .grant_idx, .ch_pkt_flat,
      .rd_pkt, .rd_src, .rd_dst, .rd_cnt, .rd_size, .rd_sinc, .rd_dinc,
      .upd_v, .upd_pkt, .upd_src, .upd_dst, .upd_cnt, .clr_o(clr),
      .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_be, .bus_rdata, .bus_gnt
   );

   // R1: quiet after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!bus_req && !irq));

endmodule

// File: tb/pkt_dma_tb_top.sv
module pkt_dma_tb_top;

   localparam int NCH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [NCH-1:0] chan_req = '0;
   logic        bus_req, bus_we, irq;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic [3:0]  bus_be;
   logic        bus_gnt = 1'b1;

   always #2.5 clk = ~clk;

   pkt_dma dut_i (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .chan_req,
      .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_be, .bus_rdata, .bus_gnt, .irq
   );

   // ---------------- memory model: 1 KiB, single process owns it
   logic [31:0] mem [256];
   logic [31:0] wlog [16];
   int          wcnt;
   logic        mem_init = 1'b0;

   function automatic logic [31:0] init_word(input int i);
      logic [7:0] b;
      b = i[7:0];
      return (i < 128) ? {b ^ 8'hC3, b + 8'h11, ~b, b} : 32'd0;
   endfunction

   assign bus_rdata = mem[bus_addr[9:2]];

   always @(posedge clk) begin
      if (mem_init) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
         wcnt <= 0;
      end else if (bus_req && bus_we && bus_gnt) begin
         for (int l = 0; l < 4; l++)
            if (bus_be[l]) mem[bus_addr[9:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
         wlog[wcnt[3:0]] <= bus_addr;
         wcnt <= wcnt + 1;
      end
   end

   // grant pattern: always, or two of every three cycles
   logic stall_on = 1'b0;
   int   stall_ctr = 0;
   always @(negedge clk) begin
      stall_ctr <= stall_ctr + 1;
      bus_gnt   <= !stall_on || (stall_ctr % 3 != 0);
   end

   // ---------------- bench bookkeeping
   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [7:0] exp_b [1024];

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a[11:0]; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [31:0] cfgword(input bit sinc, input bit dinc, input int sz,
                                           input bit ie);
      return {27'd0, ie, sz[1:0], dinc, sinc};
   endfunction

   task automatic set_pkt(input int p, input logic [31:0] c, input int s, input int d,
                          input int n);
      wr(16*p + 0, c);
      wr(16*p + 4, s);
      wr(16*p + 8, d);
      wr(16*p + 12, n);
   endtask

   task automatic bind_ch(input int c, input int p, input bit en, input bit rq);
      wr('h400 + 4*c, {22'd0, rq, en, 3'd0, p[4:0]});
   endtask

   task automatic reload();
      @(negedge clk); mem_init = 1'b1;
      @(negedge clk); mem_init = 1'b0;
      for (int a = 0; a < 1024; a++) begin
         logic [31:0] w;
         w = init_word(a / 4);
         exp_b[a] = w[8*(a%4) +: 8];
      end
   endtask

   // arithmetic copy model from the requirement text (R4, R5, R6)
   task automatic model_copy(input int s, input int d, input int n, input int sz,
                             input bit sinc, input bit dinc);
      int step;
      step = 1 << sz;
      for (int k = 0; k < n; k++) begin
         int sa, da;
         sa = sinc ? s + k*step : s;
         da = dinc ? d + k*step : d;
         for (int j = 0; j < step; j++) exp_b[da + j] = exp_b[sa + j];
      end
   endtask

   task automatic compare_mem(input string tag);
      int bad;
      logic [7:0] a_act, a_exp;
      bad = -1;
      a_act = '0; a_exp = '0;
      for (int a = 1023; a >= 0; a--) begin
         logic [31:0] w;
         w = mem[a/4];
         if (w[8*(a%4) +: 8] !== exp_b[a]) begin
            bad = a; a_act = w[8*(a%4) +: 8]; a_exp = exp_b[a];
         end
      end
      check(bad < 0, $sformatf("%s byte@%0h", tag, bad), {24'd0, a_act}, {24'd0, a_exp});
   endtask

   // ---------------- watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- stimulus
   initial begin
      reload();
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      check(bus_req == 1'b0, "R1 bus_req after reset", {31'd0, bus_req}, 0);
      check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
      cyc(10);
      check(wcnt == 0, "R1 no traffic after reset", wcnt, 0);

      // R2 R4 R5 R6 R7: sweep size and alignment, free-running mode
      for (int sz = 0; sz < 3; sz++) begin
         for (int so = 0; so < 4; so += (1 << sz)) begin
            for (int dof = 0; dof < 4; dof += (1 << sz)) begin
               reload();
               set_pkt(0, cfgword(1, 1, sz, 1), 'h010 + so, 'h200 + dof, 5);
               bind_ch(0, 0, 1, 0);
               wr('h800, 32'h1);
               cyc(30);
               model_copy('h010 + so, 'h200 + dof, 5, sz, 1, 1);
               compare_mem($sformatf("R4 R6 size%0d so%0d do%0d", sz, so, dof));
               check(wcnt == 5, "R4 element count", wcnt, 5);
               check(irq == 1'b1, "R7 irq after block", {31'd0, irq}, 1);
               wr('h804, 32'h1);
               cyc(1);
               check(irq == 1'b0, "R7 irq after ack", {31'd0, irq}, 0);
            end
         end
      end

      // R5 fixed source
      reload();
      set_pkt(0, cfgword(0, 1, 2, 1), 'h020, 'h240, 4);
      wr('h800, 32'h1);
      cyc(30);
      model_copy('h020, 'h240, 4, 2, 0, 1);
      compare_mem("R5 fixed source");
      wr('h804, 32'h1);

      // R5 fixed destination: last source word remains
      reload();
      set_pkt(0, cfgword(1, 0, 2, 1), 'h030, 'h260, 4);
      wr('h800, 32'h1);
      cyc(30);
      check(mem['h260 >> 2] == init_word(('h03C) >> 2), "R5 fixed destination",
            mem['h260 >> 2], init_word('h03C >> 2));
      check(mem['h264 >> 2] == 32'd0, "R5 fixed destination neighbour",
            mem['h264 >> 2], 0);
      wr('h804, 32'h1);

      // R7 interrupt enable clear: block completes, irq stays low
      reload();
      set_pkt(0, cfgword(1, 1, 2, 0), 'h000, 'h200, 3);
      wr('h800, 32'h1);
      cyc(25);
      model_copy('h000, 'h200, 3, 2, 1, 1);
      compare_mem("R7 no-irq block data");
      check(irq == 1'b0, "R7 irq masked", {31'd0, irq}, 0);
      wr('h804, 32'h1);

      // R11 restart continues from reached addresses
      reload();
      set_pkt(1, cfgword(1, 1, 2, 1), 'h040, 'h280, 3);
      bind_ch(0, 1, 1, 0);
      wr('h800, 32'h2);
      cyc(25);
      wr('h804, 32'h2);
      wr(16*1 + 12, 2);
      wr('h800, 32'h2);
      cyc(20);
      model_copy('h040, 'h280, 5, 2, 1, 1);
      compare_mem("R11 restart data");
      check(wcnt == 5, "R11 restart element count", wcnt, 5);
      check(irq == 1'b1, "R11 irq after restart", {31'd0, irq}, 1);
      wr('h804, 32'hFFFF_FFFF);
      bind_ch(0, 1, 0, 0);

      // R10 gating: channel off, packet disarmed, count zero
      reload();
      set_pkt(2, cfgword(1, 1, 2, 0), 'h000, 'h2C0, 2);
      bind_ch(6, 2, 0, 0);
      wr('h800, 32'h4);
      cyc(30);
      check(wcnt == 0, "R10 channel disabled", wcnt, 0);
      wr('h808, 32'h4);
      bind_ch(6, 2, 1, 0);
      cyc(30);
      check(wcnt == 0, "R10 packet disarmed", wcnt, 0);
      wr(16*2 + 12, 0);
      wr('h800, 32'h4);
      cyc(30);
      check(wcnt == 0, "R10 zero count", wcnt, 0);
      wr(16*2 + 12, 2);
      cyc(30);
      check(wcnt == 2, "R10 runs once all set", wcnt, 2);
      bind_ch(6, 2, 0, 0);
      wr('h804, 32'hFFFF_FFFF);

      // R8 request-paced channel
      reload();
      set_pkt(5, cfgword(1, 1, 2, 1), 'h040, 'h2C0, 3);
      bind_ch(3, 5, 1, 1);
      wr('h800, 32'h20);
      cyc(20);
      check(wcnt == 0, "R8 no request no move", wcnt, 0);
      chan_req[3] = 1'b1;
      cyc(30);
      check(wcnt == 1, "R8 one element per edge", wcnt, 1);
      cyc(20);
      check(wcnt == 1, "R8 held request moves one", wcnt, 1);
      chan_req[3] = 1'b0; cyc(2); chan_req[3] = 1'b1;
      cyc(20);
      check(wcnt == 2, "R8 second edge", wcnt, 2);
      chan_req[3] = 1'b0; cyc(2); chan_req[3] = 1'b1;
      cyc(20);
      chan_req[3] = 1'b0;
      check(wcnt == 3, "R8 third edge", wcnt, 3);
      check(irq == 1'b1, "R8 R7 paced block completes", {31'd0, irq}, 1);
      model_copy('h040, 'h2C0, 3, 2, 1, 1);
      compare_mem("R8 paced data");
      bind_ch(3, 5, 0, 0);
      wr('h804, 32'hFFFF_FFFF);

      // R9 lower channel first when both start together
      reload();
      set_pkt(2, cfgword(1, 1, 2, 0), 'h000, 'h300, 2);
      set_pkt(7, cfgword(1, 1, 2, 0), 'h080, 'h380, 2);
      bind_ch(2, 2, 1, 0);
      bind_ch(1, 7, 1, 0);
      wr('h800, 32'h84);
      cyc(30);
      check(wcnt == 4, "R9 total elements", wcnt, 4);
      check(wlog[0] == 32'h380, "R9 order 0", wlog[0], 32'h380);
      check(wlog[1] == 32'h384, "R9 order 1", wlog[1], 32'h384);
      check(wlog[2] == 32'h300, "R9 order 2", wlog[2], 32'h300);
      check(wlog[3] == 32'h304, "R9 order 3", wlog[3], 32'h304);
      bind_ch(2, 2, 0, 0);
      bind_ch(1, 7, 0, 0);

      // R9 re-arbitration after each element
      reload();
      set_pkt(9, cfgword(1, 1, 2, 0), 'h000, 'h300, 3);
      set_pkt(10, cfgword(1, 1, 2, 0), 'h080, 'h380, 1);
      bind_ch(4, 10, 1, 1);
      bind_ch(5, 9, 1, 0);
      wr('h800, 32'h400);
      wr('h800, 32'h200);
      for (int g = 0; g < 40; g++) begin
         if (bus_req && bus_we) break;
         @(negedge clk);
      end
      chan_req[4] = 1'b1;
      cyc(30);
      chan_req[4] = 1'b0;
      check(wcnt == 4, "R9 interleave count", wcnt, 4);
      check(wlog[0] == 32'h300, "R9 interleave 0", wlog[0], 32'h300);
      check(wlog[1] == 32'h380, "R9 interleave 1", wlog[1], 32'h380);
      check(wlog[2] == 32'h304, "R9 interleave 2", wlog[2], 32'h304);
      check(wlog[3] == 32'h308, "R9 interleave 3", wlog[3], 32'h308);
      bind_ch(4, 10, 0, 0);
      bind_ch(5, 9, 0, 0);

      // R12 stalled grants keep data correct
      reload();
      stall_on = 1'b1;
      set_pkt(0, cfgword(1, 1, 1, 0), 'h062, 'h2A2, 7);
      bind_ch(0, 0, 1, 0);
      wr('h800, 32'h1);
      cyc(120);
      stall_on = 1'b0;
      model_copy('h062, 'h2A2, 7, 1, 1, 1);
      compare_mem("R12 stalled copy");
      check(wcnt == 7, "R12 stalled count", wcnt, 7);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule